// File: doc/BRIEF.md
# Fuse-Backed Threshold Trim Register

This block keeps a small threshold trim word for a sensor front end. The permanent part of the word sits in a bank of one-time fuses. A volatile trial value can be laid over those fuses while the best setting is being found. Commands come from an upstream pulse decoder as single-cycle strobes:

- A selection strobe carries a register key and a try/blow mode.
- A step strobe marks one addressing pulse.
- A blow strobe fires the addressed fuse.

A power-cycle input clears every volatile piece of state. The fuses and the lock survive it. Only the fabrication reset `rst_n` returns the die to its virgin state.

Trial values are reached by counting steps upward from 1. Register key 0 applies the count directly. Register key 1 applies the bitwise complement of the count, so an operator can sweep the threshold down from the top. In blow mode the step count selects exactly one fuse. Fuses build up over separate blow operations by OR. A separate lock fuse, reached through the system key 7, closes off every trim access. Only the fuse-integrity check stays reachable after the lock. That check reports a marginal-fuse result, supplied by an external comparator, on two trial codes.

Top module: `fuse_trim_reg`

## Requirements
- R1: After `rst_n` low, `trim_o` is 0 and `locked_o`, `err_o` and `marg_o` are all 0.
- R2: A selection of key 0 in try mode (`blow_mode_i`=0) sets the trial code to 1. Each step strobe adds 1, and the code saturates at all ones. While this session is open, `trim_o` equals fuses OR code.
- R3: A selection of key 1 in try mode works like R2, but the value applied is the bitwise inverse of the code. Code 1 gives 111110.
- R4: A selection of key 0 in blow mode (`blow_mode_i`=1) starts from address 0. After n steps, with 1≤n≤TRIM_W, only bit n-1 is addressed. A blow then sets that fuse. Fuses build up by OR: bit 1 followed by bit 0 gives 3.
- R5: A blow strobe is refused if any of these holds:
  - no session is open;
  - the session is in try mode;
  - the key is 1;
  - the address is zero (0 steps, or more than TRIM_W steps);
  - key 7 is used with any address other than bit LOCK_BIT.
  A refused blow leaves every fuse unchanged and raises `err_o` for the single cycle after the strobe.
- R6: `por_i` closes the session and drops the trial value. The fuses and `locked_o` keep their values.
- R7: Key 7 in blow mode with address bit LOCK_BIT (4 steps by default), followed by a blow, sets `locked_o` for good.
- R8: Once locked, selections of key 0 and key 1 open nothing, so `trim_o` stays equal to the fuses. Every blow is refused as in R5.
- R9: Key 7 in try mode is the fuse check. At code CHK_LO (7), `marg_o` follows `margin_lo_i`. At code CHK_HI (15), `marg_o` follows `margin_hi_i`. At any other code, `marg_o` is 0. The check works both before and after locking.
- R10: Outside a try session on key 0 or key 1, `trim_o` equals the fuse bits alone.
- R11: A blown fuse never clears, and at most one fuse changes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Fabrication reset, active low; clears the fuses too |
| por_i | input | 1 | Power-cycle strobe; clears volatile state only |
| sel_stb_i | input | 1 | Register selection strobe |
| key_i | input | 3 | Register key carried with the selection |
| blow_mode_i | input | 1 | Mode carried with the selection: 0 try, 1 blow |
| step_stb_i | input | 1 | One addressing pulse |
| blow_stb_i | input | 1 | Blow pulse |
| margin_lo_i | input | 1 | Comparator result against the low fuse threshold |
| margin_hi_i | input | 1 | Comparator result against the high fuse threshold |
| trim_o | output | TRIM_W | Effective trim word |
| locked_o | output | 1 | Lock fuse state |
| err_o | output | 1 | One-cycle flag for a refused blow |
| marg_o | output | 1 | Marginal-fuse indication during the fuse check |

## Verification
The bench builds the block with its default parameters: TRIM_W=6, LOCK_BIT=3, and check codes 7 and 15. With these values the trial code reaches saturation after a few dozen steps, and seven blow-mode steps run past the top fuse into the zero address. The 6-bit code can also reach both check codes, so the low-threshold and high-threshold results can be told apart. Fuse state is deliberately carried from one scenario into the next. The overlay, the power cycle and the lock therefore all act on fuses that were blown earlier.

// File: rtl/ftr_pkg.sv
package ftr_pkg;
  typedef enum logic {MODE_TRY = 1'b0, MODE_BLOW = 1'b1} ftr_mode_e;

  localparam logic [2:0] KEY_UP  = 3'd0;
  localparam logic [2:0] KEY_DN  = 3'd1;
  localparam logic [2:0] KEY_SYS = 3'd7;

  typedef struct packed {
    logic      act;
    logic [2:0] key;
    ftr_mode_e mode;
  } ftr_sess_t;
endpackage

// File: rtl/ftr_session.sv
module ftr_session
  import ftr_pkg::*;
#(
  parameter int unsigned TRIM_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_i,
  input  logic              sel_stb_i,
  input  logic [2:0]        key_i,
  input  logic              blow_mode_i,
  input  logic              step_stb_i,
  input  logic              locked_i,
  output ftr_sess_t         sess_o,
  output logic [TRIM_W-1:0] code_o
);
  localparam logic [TRIM_W-1:0] CODE_MAX = '1;

  function automatic logic [TRIM_W-1:0] sat_inc(input logic [TRIM_W-1:0] c);
    return (c == CODE_MAX) ? c : c + TRIM_W'(1);
  endfunction

  ftr_sess_t         sess_q;
  logic [TRIM_W-1:0] code_q;
  ftr_mode_e         mode_in;
  logic              key_known;
  logic              sel_ok;

  assign mode_in   = ftr_mode_e'(blow_mode_i);
  assign key_known = (key_i == KEY_UP) || (key_i == KEY_DN) || (key_i == KEY_SYS);
  assign sel_ok    = key_known && (!locked_i || (key_i == KEY_SYS && mode_in == MODE_TRY));

  always_ff @(posedge clk) begin
    if (!rst_n || por_i) begin
      sess_q <= '{act: 1'b0, key: 3'd0, mode: MODE_TRY};
      code_q <= '0;
    end else if (sel_stb_i) begin
      sess_q <= '{act: sel_ok, key: key_i, mode: mode_in};
      code_q <= (mode_in == MODE_BLOW) ? '0 : TRIM_W'(1);
    end else if (step_stb_i && sess_q.act) begin
      code_q <= sat_inc(code_q);
    end
  end

  assign sess_o = sess_q;
  assign code_o = code_q;

  // R8
  locked_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_stb_i && locked_i && !por_i && key_i != KEY_SYS) |=> !sess_q.act);

  // R2
  code_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_stb_i && !por_i && sess_q.act) |=> (code_q >= $past(code_q)));
endmodule

// File: rtl/ftr_fuse_bank.sv
module ftr_fuse_bank
  import ftr_pkg::*;
#(
  parameter int unsigned TRIM_W   = 6,
  parameter int unsigned LOCK_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_i,
  input  logic              blow_stb_i,
  input  ftr_sess_t         sess_i,
  input  logic [TRIM_W-1:0] code_i,
  output logic [TRIM_W-1:0] fuse_o,
  output logic              locked_o,
  output logic              err_o
);
  localparam logic [TRIM_W-1:0] LOCK_ADDR = TRIM_W'(1) << LOCK_BIT;

  function automatic logic [TRIM_W-1:0] onehot_addr(input logic [TRIM_W-1:0] c);
    logic [TRIM_W-1:0] r;
    r = '0;
    for (int i = 0; i < TRIM_W; i++) r[i] = (c == TRIM_W'(i + 1));
    return r;
  endfunction

  logic [TRIM_W-1:0] fuse_q;
  logic              lock_q;
  logic              err_q;
  logic [TRIM_W-1:0] addr;
  logic              in_blow;
  logic              trim_hit;
  logic              lock_hit;
  logic              blow_ok;
  logic              blow_bad;

  assign addr     = onehot_addr(code_i);
  assign in_blow  = sess_i.act && sess_i.mode == MODE_BLOW;
  assign trim_hit = in_blow && sess_i.key == KEY_UP && (|addr);
  assign lock_hit = in_blow && sess_i.key == KEY_SYS && addr == LOCK_ADDR;
  assign blow_ok  = blow_stb_i && !lock_q && (trim_hit || lock_hit);
  assign blow_bad = blow_stb_i && !blow_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fuse_q <= '0;
      lock_q <= 1'b0;
    end else if (blow_ok) begin
      if (trim_hit) fuse_q <= fuse_q | addr;
      if (lock_hit) lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || por_i) err_q <= 1'b0;
    else                 err_q <= blow_bad;
  end

  assign fuse_o   = fuse_q;
  assign locked_o = lock_q;
  assign err_o    = err_q;

  // R11
  fuse_never_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~fuse_q & $past(fuse_q)) == '0));

  // R11
  single_fuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(fuse_q ^ $past(fuse_q)) <= 1));

  // R5
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(blow_bad));

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R8
  locked_no_blow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blow_stb_i && lock_q && !por_i) |=> ($stable(fuse_q) && err_q));
endmodule

// File: rtl/ftr_trim_mux.sv
module ftr_trim_mux
  import ftr_pkg::*;
#(
  parameter int unsigned TRIM_W = 6,
  parameter int unsigned CHK_LO = 7,
  parameter int unsigned CHK_HI = 15
) (
  input  ftr_sess_t         sess_i,
  input  logic [TRIM_W-1:0] code_i,
  input  logic [TRIM_W-1:0] fuse_i,
  input  logic              margin_lo_i,
  input  logic              margin_hi_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              marg_o
);
  function automatic logic [TRIM_W-1:0] try_value(input logic [TRIM_W-1:0] c, input logic down);
    return down ? ~c : c;
  endfunction

  logic try_live;
  logic chk_live;

  assign try_live = sess_i.act && sess_i.mode == MODE_TRY &&
                    (sess_i.key == KEY_UP || sess_i.key == KEY_DN);
  assign chk_live = sess_i.act && sess_i.mode == MODE_TRY && sess_i.key == KEY_SYS;

  assign trim_o = try_live ? (fuse_i | try_value(code_i, sess_i.key == KEY_DN)) : fuse_i;
  assign marg_o = chk_live && ((code_i == TRIM_W'(CHK_LO) && margin_lo_i) ||
                               (code_i == TRIM_W'(CHK_HI) && margin_hi_i));

  // R9
  always_comb begin
    marg_scope_chk: assert (!marg_o || chk_live);
  end
endmodule

// File: rtl/fuse_trim_reg.sv
module fuse_trim_reg
  import ftr_pkg::*;
#(
  parameter int unsigned TRIM_W   = 6,
  parameter int unsigned LOCK_BIT = 3,
  parameter int unsigned CHK_LO   = 7,
  parameter int unsigned CHK_HI   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_i,
  input  logic              sel_stb_i,
  input  logic [2:0]        key_i,
  input  logic              blow_mode_i,
  input  logic              step_stb_i,
  input  logic              blow_stb_i,
  input  logic              margin_lo_i,
  input  logic              margin_hi_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              locked_o,
  output logic              err_o,
  output logic              marg_o
);
  ftr_sess_t         sess;
  logic [TRIM_W-1:0] code;
  logic [TRIM_W-1:0] fuse;
  logic              locked;

  ftr_session #(.TRIM_W(TRIM_W)) u_session (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .sel_stb_i(sel_stb_i), .key_i(key_i),
    .blow_mode_i(blow_mode_i), .step_stb_i(step_stb_i), .locked_i(locked),
    .sess_o(sess), .code_o(code));

  ftr_fuse_bank #(.TRIM_W(TRIM_W), .LOCK_BIT(LOCK_BIT)) u_fuses (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .blow_stb_i(blow_stb_i), .sess_i(sess),
    .code_i(code), .fuse_o(fuse), .locked_o(locked), .err_o(err_o));

  ftr_trim_mux #(.TRIM_W(TRIM_W), .CHK_LO(CHK_LO), .CHK_HI(CHK_HI)) u_mux (
    .sess_i(sess), .code_i(code), .fuse_i(fuse), .margin_lo_i(margin_lo_i),
    .margin_hi_i(margin_hi_i), .trim_o(trim_o), .marg_o(marg_o));

  assign locked_o = locked;

  // R10
  blow_session_fuse_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sess.mode == MODE_BLOW) |-> (trim_o == fuse));
endmodule

// File: tb/fuse_trim_reg_tb.sv
module fuse_trim_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_i = 1'b0;
  logic       sel_stb_i = 1'b0;
  logic [2:0] key_i = 3'd0;
  logic       blow_mode_i = 1'b0;
  logic       step_stb_i = 1'b0;
  logic       blow_stb_i = 1'b0;
  logic       margin_lo_i = 1'b0;
  logic       margin_hi_i = 1'b0;
  logic [5:0] trim_o;
  logic       locked_o, err_o, marg_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fuse_trim_reg u_dut (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .sel_stb_i(sel_stb_i), .key_i(key_i),
    .blow_mode_i(blow_mode_i), .step_stb_i(step_stb_i), .blow_stb_i(blow_stb_i),
    .margin_lo_i(margin_lo_i), .margin_hi_i(margin_hi_i), .trim_o(trim_o),
    .locked_o(locked_o), .err_o(err_o), .marg_o(marg_o));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic select(input int key, input bit blow);
    key_i = 3'(key); blow_mode_i = blow; sel_stb_i = 1'b1;
    @(negedge clk); sel_stb_i = 1'b0;
  endtask

  task automatic step(input int n);
    if (n > 0) begin
      step_stb_i = 1'b1;
      repeat (n) @(negedge clk);
      step_stb_i = 1'b0;
    end
  endtask

  task automatic blow(output bit err);
    blow_stb_i = 1'b1;
    @(negedge clk); blow_stb_i = 1'b0;
    err = err_o;
    @(negedge clk);
  endtask

  task automatic power_cycle();
    por_i = 1'b1; @(negedge clk); por_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 trim", trim_o, 0);
    chk("R1 locked", locked_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 marg", marg_o, 0);
  endtask

  task automatic t_try_up();
    select(0, 0);
    chk("R2 start code", trim_o, 1);
    step(4);
    chk("R2 after 4 steps", trim_o, 5);
    step(70);
    chk("R2 saturation", trim_o, 63);
  endtask

  task automatic t_try_down();
    select(1, 0);
    chk("R3 code 1 inverted", trim_o, 62);
    step(2);
    chk("R3 code 3 inverted", trim_o, 60);
    power_cycle();
    chk("R6 trial dropped", trim_o, 0);
  endtask

  task automatic t_blow_accumulate();
    bit e;
    select(0, 1);
    chk("R10 blow session shows fuses", trim_o, 0);
    step(2);
    chk("R10 address not applied", trim_o, 0);
    blow(e);
    chk("R4 blow bit1 err", e, 0);
    chk("R4 bit1 blown", trim_o, 2);
    power_cycle();
    chk("R6 fuse survives power cycle", trim_o, 2);
    select(0, 1); step(1); blow(e);
    chk("R4 OR accumulation", trim_o, 3);
  endtask

  task automatic t_bad_blows();
    bit e;
    select(0, 1); blow(e);
    chk("R5 zero address err", e, 1);
    chk("R5 err one cycle", err_o, 0);
    step(7); blow(e);
    chk("R5 over-range address err", e, 1);
    select(1, 1); step(1); blow(e);
    chk("R5 key 1 blow err", e, 1);
    select(0, 0); blow(e);
    chk("R5 try mode blow err", e, 1);
    chk("R5 fuses kept (try overlay 3|1)", trim_o, 3);
    power_cycle(); blow(e);
    chk("R5 no session err", e, 1);
    chk("R5 fuses unchanged", trim_o, 3);
  endtask

  task automatic t_overlay();
    select(0, 0); step(3);
    chk("R2 overlay fuse|4", trim_o, 7);
    select(1, 0);
    chk("R3 overlay fuse|62", trim_o, 63);
    select(0, 1);
    chk("R10 back to fuses only", trim_o, 3);
  endtask

  task automatic t_fuse_check(input string tag);
    margin_lo_i = 1'b1; margin_hi_i = 1'b0;
    select(7, 0); step(6);
    #1 chk({"R9 low threshold ", tag}, marg_o, 1);
    step(1);
    #1 chk({"R9 code 8 silent ", tag}, marg_o, 0);
    step(7);
    #1 chk({"R9 code 15 ignores low ", tag}, marg_o, 0);
    margin_hi_i = 1'b1;
    #1 chk({"R9 high threshold ", tag}, marg_o, 1);
    margin_lo_i = 1'b0; margin_hi_i = 1'b0;
  endtask

  task automatic t_lock();
    bit e;
    select(7, 1); step(3); blow(e);
    chk("R7 wrong lock address err", e, 1);
    chk("R7 still unlocked", locked_o, 0);
    select(7, 1); step(4); blow(e);
    chk("R7 lock blow err", e, 0);
    chk("R7 locked", locked_o, 1);
  endtask

  task automatic t_after_lock();
    bit e;
    select(0, 0); step(3);
    chk("R8 up session refused", trim_o, 3);
    select(1, 0);
    chk("R8 down session refused", trim_o, 3);
    select(0, 1); step(3); blow(e);
    chk("R8 blow refused err", e, 1);
    chk("R8 fuses unchanged", trim_o, 3);
    power_cycle();
    chk("R6 lock survives power cycle", locked_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_try_up();
    t_try_down();
    t_blow_accumulate();
    t_bad_blows();
    t_overlay();
    t_fuse_check("before lock");
    t_lock();
    t_after_lock();
    t_fuse_check("after lock");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule